// File: doc/BRIEF.md
# Tap-Programmed Serial-Output FIFO Slice

This block stores 9-bit words written over a parallel port and sends them out as a serial bitstream, least significant bit first, on its clock. Nine tap outputs form a thermometer-style sequencer. The tap the user connects back to the read strobe input fixes how many bits of each stored word are shifted. With tap k connected, a fresh word is fetched every k+1 clocks and its bits 0 to k leave in order, with no gap between words.

Slices can be chained to build a serial word longer than nine bits. The leading slice has its cascade input held high. Every later slice takes its cascade input from tap 8 of the slice before it, and all slices share one read strobe, driven from the chosen tap of the last slice. The shared serial line is modelled as a data bit plus an output enable. Only the slice that is shifting raises its enable.

Top module: `tap_serial_fifo`

## Requirements
- R1: While reset is held and immediately after it, `empty_o` is 1, `full_o` is 0, every tap is 0 and `sd_oe_o` is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` when the FIFO is not full. `empty_o` falls only after a write. `full_o` is 1 once DEPTH words are held, and a write made while full is dropped: that word never appears on the serial output.
- R3: With `ser_mode_ni` high, all taps are forced to 0 on the next clock and `sd_oe_o` is 0. With it low, the sequencer may run.
- R4: The clock edge that starts a word leaves only tap 0 high. Each later edge within the word also raises the next higher tap, and the taps already high stay high. The taps saturate once all nine are high.
- R5: With the read strobe fed from tap k (0 to 8), a standalone slice fetches a new word every k+1 clocks. It emits exactly bits 0 to k of each word, and consecutive words follow back to back.
- R6: Bits leave least significant first: stored bit 0 is the first serial bit of a word.
- R7: A word start that finds the FIFO empty fetches nothing. `sd_oe_o` stays 0 for that word, and the taps still run.
- R8: A slice that is idle starts a word on the first edge at which its cascade input is high. A slice whose cascade input has been low since reset clears its taps at the end of the word and waits. A slice whose cascade input has never been low starts the next word on that same edge.
- R9: A slice drives the serial line only while it shifts its own bits. It releases the line on the edge after its ninth bit when the word continues into a later slice, so that at no time do two chained slices drive at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for writes and serial shifting |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_mode_ni | input | 1 | Low selects serial output operation |
| wr_en_i | input | 1 | Parallel write strobe |
| wr_data_i | input | 9 | Parallel write word |
| full_o | output | 1 | FIFO holds DEPTH words |
| empty_o | output | 1 | FIFO holds no word |
| casc_i | input | 1 | Cascade enable (tie high when standalone) |
| rd_i | input | 1 | Read strobe, fed back from a chosen tap |
| tap_o | output | 9 | Sequencer taps, tap 0 in bit 0 |
| sd_o | output | 1 | Serial data bit |
| sd_oe_o | output | 1 | Drive enable for the shared serial line |

## Verification
The standalone slice is read with the strobe on taps 5, 8 and 0. These give a mid-length word, a full 9-bit word and a 1-bit word. Together they show whether the fetch period follows the chosen tap, and whether the restart edge overlaps correctly with the first bit of the next word. Distinct bit patterns in each word expose any bit-order or truncation error. A FIFO that is filled and then written once more, and a FIFO drained into empty word slots, show whether dropped writes and empty fetches leak onto the line. A two-slice chain with a 13-bit word checks three things: the hand-off at tap 8, the idle wait of the upper slice, and that the two slices never drive together.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned TAP_N  = 9;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TAP_N-1:0]  tap_t;
endpackage

// File: rtl/tsf_store.sv
module tsf_store
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t push_data_i,
  input  logic  pop_i,
  output word_t pop_data_o,
  output logic  full_o,
  output logic  empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  word_t mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tsf_seq.sv
module tsf_seq
  import tsf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic casc_i,
  input  logic rd_i,
  output tap_t tap_o,
  output logic start_o,
  output logic live_o
);
  tap_t tap_q, tap_d;
  logic done_q, done_d;
  logic head_q;
  logic busy, restart, launch;

  assign busy    = |tap_q;
  // head: cascade input never seen low since reset
  assign restart = run_i && busy && rd_i && head_q && casc_i;
  assign launch  = run_i && !busy && casc_i;
  assign start_o = restart || launch;
  assign tap_o   = tap_q;
  assign live_o  = busy && !done_q;

  always_comb begin
    if (!run_i)             tap_d = '0;
    else if (busy && rd_i)  tap_d = restart ? tap_t'(1) : '0;
    else if (launch)        tap_d = tap_t'(1);
    else if (busy)          tap_d = {tap_q[TAP_N-2:0], 1'b1};
    else                    tap_d = '0;
  end

  always_comb begin
    if (!run_i || start_o || (busy && rd_i)) done_d = 1'b0;
    else if (busy && tap_q[TAP_N-1])         done_d = 1'b1;
    else                                     done_d = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q  <= '0;
      done_q <= 1'b0;
      head_q <= 1'b1;
    end else begin
      tap_q  <= tap_d;
      done_q <= done_d;
      head_q <= head_q & casc_i;
    end
  end
endmodule

// File: rtl/tsf_shift.sv
module tsf_shift
  import tsf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  avail_i,
  input  word_t word_i,
  input  logic  live_i,
  output logic  sd_o,
  output logic  sd_oe_o
);
  word_t sh_q;
  logic  loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      loaded_q <= 1'b0;
    end else if (start_i) begin
      sh_q     <= avail_i ? word_i : '0;
      loaded_q <= avail_i;
    end else begin
      sh_q     <= sh_q >> 1;
    end
  end

  assign sd_oe_o = loaded_q && live_i;
  assign sd_o    = sd_oe_o && sh_q[0];
endmodule

// File: rtl/tap_serial_fifo.sv
module tap_serial_fifo
  import tsf_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              empty_o,
  input  logic              casc_i,
  input  logic              rd_i,
  output logic [TAP_N-1:0]  tap_o,
  output logic              sd_o,
  output logic              sd_oe_o
);
  word_t fetch_word;
  logic  start, live;

  tsf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(wr_en_i), .push_data_i(wr_data_i),
    .pop_i(start), .pop_data_o(fetch_word),
    .full_o(full_o), .empty_o(empty_o)
  );

  tsf_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(!ser_mode_ni),
    .casc_i(casc_i), .rd_i(rd_i),
    .tap_o(tap_o), .start_o(start), .live_o(live)
  );

  tsf_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start), .avail_i(!empty_o), .word_i(fetch_word),
    .live_i(live), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );
endmodule

// File: rtl/tap_serial_fifo_chk.sv
module tap_serial_fifo_chk
  import tsf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_mode_ni,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              casc_i,
  input logic              rd_i,
  input logic [TAP_N-1:0]  tap_o,
  input logic              sd_o,
  input logic              sd_oe_o
);
  p_flags_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_fill_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(wr_en_i));

  p_mode_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_mode_ni |=> (tap_o == '0) && !sd_oe_o);

  p_tap_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_mode_ni && (tap_o != '0) && !rd_i && !tap_o[TAP_N-1])
      |=> tap_o == {$past(tap_o[TAP_N-2:0]), 1'b1});

  p_drive_from_q0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_oe_o) |-> tap_o == TAP_N'(1));

  p_drive_in_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> tap_o != '0);
endmodule

bind tap_serial_fifo tap_serial_fifo_chk u_chk (.*);

// File: tb/tap_serial_fifo_test.sv
module tap_serial_fifo_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_a = 1'b1, mode_b = 1'b1;
  logic wr_a = 1'b0, wr_b = 1'b0;
  logic [8:0] d_a = '0, d_b = '0;
  logic chain = 1'b0;
  int   sel_a = 5, sel_b = 3;
  logic full_a, empty_a, full_b, empty_b;
  logic [8:0] tap_a, tap_b;
  logic sd_a, oe_a, sd_b, oe_b, rd;

  int tests = 0, fails = 0;
  bit exp_q[$];
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign rd = chain ? tap_b[sel_b] : tap_a[sel_a];

  tap_serial_fifo #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_ni(mode_a),
    .wr_en_i(wr_a), .wr_data_i(d_a), .full_o(full_a), .empty_o(empty_a),
    .casc_i(1'b1), .rd_i(rd), .tap_o(tap_a), .sd_o(sd_a), .sd_oe_o(oe_a));

  tap_serial_fifo #(.DEPTH(DEPTH)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_ni(mode_b),
    .wr_en_i(wr_b), .wr_data_i(d_b), .full_o(full_b), .empty_o(empty_b),
    .casc_i(tap_a[8]), .rd_i(rd), .tap_o(tap_b), .sd_o(sd_b), .sd_oe_o(oe_b));

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_bits(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(w[i]);
  endtask

  task automatic write_a(input logic [8:0] w);
    @(negedge clk); wr_a = 1'b1; d_a = w;
    @(negedge clk); wr_a = 1'b0;
  endtask

  task automatic write_b(input logic [8:0] w);
    @(negedge clk); wr_b = 1'b1; d_b = w;
    @(negedge clk); wr_b = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: shared line resolution and scoreboard compare
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (oe_a && oe_b) check("R9", "two drivers", 1, 0);
      if (oe_a || oe_b) begin
        if (exp_q.size() == 0) check("R7", "unexpected drive", 1, 0);
        else check("R6", "serial bit", int'(oe_a ? sd_a : sd_b), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1", "empty in reset", int'(empty_a), 1);
    check("R1", "taps in reset", int'(tap_a), 0);
    rst_n = 1'b1;
    idle(1);
    check("R1", "empty after reset", int'(empty_a), 1);
    check("R1", "full after reset", int'(full_a), 0);
    check("R1", "oe after reset", int'(oe_a), 0);

    // standalone, tap 5 -> 6-bit words
    write_a(9'h1A5); write_a(9'h0C3); write_a(9'h15E);
    check("R2", "empty after writes", int'(empty_a), 0);
    push_bits(9'h1A5, 6); push_bits(9'h0C3, 6); push_bits(9'h15E, 6);
    sel_a = 5; mode_a = 1'b0;
    idle(1); check("R4", "tap step 1", int'(tap_a), 1);
    idle(1); check("R4", "tap step 2", int'(tap_a), 3);
    idle(1); check("R4", "tap step 3", int'(tap_a), 7);
    idle(4); check("R5", "tap 5 period restart", int'(tap_a), 1);
    idle(30);
    check("R5", "tap5 bits left", exp_q.size(), 0);
    check("R7", "empty after drain", int'(empty_a), 1);
    mode_a = 1'b1;
    idle(2);
    check("R3", "taps idle in parallel mode", int'(tap_a), 0);
    check("R3", "oe idle in parallel mode", int'(oe_a), 0);

    // tap 8 -> full 9-bit words
    write_a(9'h0F0); write_a(9'h12D);
    push_bits(9'h0F0, 9); push_bits(9'h12D, 9);
    sel_a = 8; mode_a = 1'b0;
    idle(9); check("R4", "taps saturate", int'(tap_a), 511);
    idle(25); check("R5", "tap8 bits left", exp_q.size(), 0);
    mode_a = 1'b1; idle(2);

    // tap 0 -> 1-bit words
    write_a(9'h001); write_a(9'h1FE); write_a(9'h0A1);
    push_bits(9'h001, 1); push_bits(9'h1FE, 1); push_bits(9'h0A1, 1);
    sel_a = 0; mode_a = 1'b0;
    idle(10); check("R5", "tap0 bits left", exp_q.size(), 0);
    mode_a = 1'b1; idle(2);

    // fill to full, extra write dropped
    for (int i = 0; i < DEPTH; i++) begin
      write_a(9'(9'h055 + 37 * i));
      push_bits(9'(9'h055 + 37 * i), 9);
    end
    check("R2", "full at depth", int'(full_a), 1);
    write_a(9'h1FF);
    check("R2", "full after dropped write", int'(full_a), 1);
    sel_a = 8; mode_a = 1'b0;
    idle(9 * DEPTH + 30);
    check("R2", "full-test bits left", exp_q.size(), 0);
    check("R2", "empty after full drain", int'(empty_a), 1);
    mode_a = 1'b1; idle(2);

    // two-slice chain, 13-bit word
    write_a(9'h1C7); write_a(9'h038);
    write_b(9'h00B); write_b(9'h004);
    push_bits(9'h1C7, 9); push_bits(9'h00B, 4);
    push_bits(9'h038, 9); push_bits(9'h004, 4);
    chain = 1'b1; sel_b = 3;
    mode_a = 1'b0; mode_b = 1'b0;
    idle(9);
    check("R8", "upper waits for tap 8", int'(tap_b), 0);
    check("R9", "lower still driving bit 8", int'(oe_a), 1);
    idle(1);
    check("R8", "upper starts", int'(tap_b), 1);
    check("R9", "lower released", int'(oe_a), 0);
    idle(4);
    check("R8", "lower restarts", int'(tap_a), 1);
    check("R8", "upper cleared", int'(tap_b), 0);
    idle(30);
    check("R8", "chain bits left", exp_q.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule